// File: doc/BRIEF.md
# Byte Parity Check and Generate Unit

This unit handles parity for one side of a 36-bit data port. The word is made of four 9-bit lanes. Bits 0-7 of each lane carry data and bit 8 of the lane carries its parity. Lanes sit at bits 0-8, 9-17, 18-26 and 27-35. The unit checks every word on the incoming bus and reports a low-active error flag. It passes write data through to an external FIFO memory untouched, and it holds a 36-bit mailbox register that the opposite port loads.

Reads take data either from the external FIFO memory or from the mailbox and place it in a registered output stage. When parity generation is selected, the stored parity bit of each lane is replaced on the way to that register with one computed from the lane's eight data bits. Storage is never changed. One set of four parity trees is shared between checking the bus and generating parity for mailbox reads. During a generating mailbox read the trees are busy with the mailbox word, so the error flag is held inactive for that read.

Top module: `byte_parity_unit`

## Requirements
- R1: A word is four 9-bit lanes at bits [8:0], [17:9], [26:18] and [35:27]. Within each lane, bits 0-7 of the lane are data and the lane MSB (bits 8, 17, 26, 35) is the parity bit.
- R2: `par_err_n` is driven combinationally from `bus_in` and `odd_sel`. With `odd_sel`=1 a lane is valid when its 9 bits hold an odd number of ones; with `odd_sel`=0 it is valid when they hold an even number. `par_err_n` is 0 when any lane is invalid and 1 otherwise, except in the case of R3.
- R3: While `cs_n`=0, `en`=1, `wr_rd`=0, `mbx_sel`=1 and `gen_par`=1 (a generating mailbox read), `par_err_n` is 1 whatever `bus_in` holds.
- R4: While `cs_n`=0, `en`=1, `wr_rd`=1 and `mbx_sel`=0, `fifo_wr_en` is 1 and `fifo_wr_data` equals all 36 bits of `bus_in`, whatever `gen_par` is. Otherwise `fifo_wr_en` is 0.
- R5: `dout` changes only on a rising `clk` edge where `cs_n`=0, `en`=1 and `wr_rd`=0. On any other edge it holds its value.
- R6: On a read edge with `gen_par`=0, `dout` takes the mailbox word when `mbx_sel`=1 and `fifo_rd_data` when `mbx_sel`=0, with all bits unchanged.
- R7: On a read edge with `gen_par`=1, the data bits of each lane pass unchanged. Each lane MSB is replaced by the bit that makes the lane's total count of ones odd (`odd_sel`=1) or even (`odd_sel`=0).
- R8: `gen_par` and `odd_sel` take effect only as sampled on the edge that loads `dout`. Later changes do not alter the loaded word.
- R9: A read with generation leaves the mailbox contents unchanged. A later read without generation returns the word exactly as written.
- R10: A rising edge with `peer_mbx_we`=1 stores `peer_mbx_data` in the mailbox and sets `mbx_full`. A mailbox read on this port clears `mbx_full`. When both occur on the same edge, `mbx_full` stays 1 and the read returns the previous mailbox word.
- R11: After asynchronous reset (`rst_n`=0), `dout`, the mailbox and `mbx_full` are all 0.
- R12: While `cs_n`=0, `en`=1, `wr_rd`=0 and `mbx_sel`=0, `fifo_rd_en` is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| en | input | 1 | Access enable |
| wr_rd | input | 1 | 1 = write, 0 = read |
| mbx_sel | input | 1 | 1 = mailbox access, 0 = FIFO access |
| gen_par | input | 1 | Generate parity on reads |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| bus_in | input | 36 | Incoming data bus |
| peer_mbx_we | input | 1 | Mailbox write strobe from the opposite port |
| peer_mbx_data | input | 36 | Mailbox write data from the opposite port |
| fifo_rd_data | input | 36 | Word read from the external FIFO memory |
| fifo_rd_en | output | 1 | FIFO read request |
| fifo_wr_en | output | 1 | FIFO write request |
| fifo_wr_data | output | 36 | FIFO write data |
| dout | output | 36 | Registered output word |
| par_err_n | output | 1 | Parity error flag, active low |
| mbx_full | output | 1 | Mailbox holds an unread word |

## Verification
The assertions assume that the control selects and `bus_in` are stable around each rising edge. They also assume that `fifo_rd_data` already holds the addressed word on the edge that loads it. The bench meets both assumptions by changing every input only just after a falling edge and sampling only at the following falling edge. The assertions also assume that `peer_mbx_we` is a single-cycle strobe; the bench raises it for exactly one edge each time. Combinational checks on `par_err_n` and the FIFO strobes are sampled one time step after the inputs change, with no clock edge in between.

// File: rtl/bpu_pkg.sv
`timescale 1ns/1ps
package bpu_pkg;

   // Decoded access of the current cycle
   typedef struct packed {
      logic rd_any;   // read of either source
      logic rd_mbx;   // read of the mailbox
      logic rd_fifo;  // read of the FIFO memory
      logic wr_fifo;  // write toward the FIFO memory
      logic borrow;   // mailbox read with generation: trees busy
   } bpu_acc_t;

   typedef enum logic {
      SRC_FIFO = 1'b0,
      SRC_MBX  = 1'b1
   } bpu_src_e;

endpackage

// File: rtl/bpu_decode.sv
`timescale 1ns/1ps
module bpu_decode
   import bpu_pkg::*;
(
   input  logic     cs_n,
   input  logic     en,
   input  logic     wr_rd,
   input  logic     mbx_sel,
   input  logic     gen_par,
   output bpu_acc_t acc,
   output bpu_src_e src
);

   logic sel;

   always_comb begin
      sel         = !cs_n && en;
      acc.rd_any  = sel && !wr_rd;
      acc.rd_mbx  = sel && !wr_rd && mbx_sel;
      acc.rd_fifo = sel && !wr_rd && !mbx_sel;
      acc.wr_fifo = sel && wr_rd && !mbx_sel;
      acc.borrow  = sel && !wr_rd && mbx_sel && gen_par;
      src         = mbx_sel ? SRC_MBX : SRC_FIFO;
   end

endmodule

// File: rtl/bpu_parity_tree.sv
`timescale 1ns/1ps
module bpu_parity_tree #(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 4
) (
   input  logic [NUM_BYTES*BYTE_W-1:0] data,
   input  logic                        odd_sel,
   output logic [NUM_BYTES-1:0]        gen_bits
);

   // Bit that completes each lane to the selected parity (R1, R7)
   for (genvar k = 0; k < NUM_BYTES; k++) begin : g_tree
      assign gen_bits[k] = (^data[k*BYTE_W +: BYTE_W]) ^ odd_sel;
   end

endmodule

// File: rtl/bpu_subst.sv
`timescale 1ns/1ps
module bpu_subst #(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 4,
   localparam int LANE     = BYTE_W + 1,
   localparam int W        = NUM_BYTES * LANE
) (
   input  logic [W-1:0]         d,
   input  logic [NUM_BYTES-1:0] gen_bits,
   input  logic                 gen_en,
   output logic [W-1:0]         q
);

   for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
      assign q[k*LANE +: BYTE_W] = d[k*LANE +: BYTE_W];
      assign q[k*LANE + BYTE_W]  = gen_en ? gen_bits[k] : d[k*LANE + BYTE_W];
   end

endmodule

// File: rtl/bpu_mailbox.sv
`timescale 1ns/1ps
module bpu_mailbox #(
   parameter int W = 36
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   input  logic         rd_take,
   output logic [W-1:0] q,
   output logic         full
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q    <= '0;
         full <= 1'b0;
      end else begin
         if (we) begin
            q    <= wdata;
            full <= 1'b1;
         end else if (rd_take) begin
            full <= 1'b0;
         end
      end
   end

   AST_MBX_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q)); // R9
   AST_MBX_FULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> full); // R10
   AST_MBX_EMPTY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_take && !we) |=> !full); // R10

endmodule

// File: rtl/bpu_out_stage.sv
`timescale 1ns/1ps
module bpu_out_stage #(
   parameter int W = 36
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q)); // R5

endmodule

// File: rtl/byte_parity_unit.sv
`timescale 1ns/1ps
module byte_parity_unit
   import bpu_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter int NUM_BYTES    = 4,
   parameter int SHARED_TREES = 1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cs_n,
   input  logic                                 en,
   input  logic                                 wr_rd,
   input  logic                                 mbx_sel,
   input  logic                                 gen_par,
   input  logic                                 odd_sel,
   input  logic [NUM_BYTES*(BYTE_W+1)-1:0]      bus_in,
   input  logic                                 peer_mbx_we,
   input  logic [NUM_BYTES*(BYTE_W+1)-1:0]      peer_mbx_data,
   input  logic [NUM_BYTES*(BYTE_W+1)-1:0]      fifo_rd_data,
   output logic                                 fifo_rd_en,
   output logic                                 fifo_wr_en,
   output logic [NUM_BYTES*(BYTE_W+1)-1:0]      fifo_wr_data,
   output logic [NUM_BYTES*(BYTE_W+1)-1:0]      dout,
   output logic                                 par_err_n,
   output logic                                 mbx_full
);

   localparam int LANE = BYTE_W + 1;
   localparam int W    = NUM_BYTES * LANE;
   localparam int DW   = NUM_BYTES * BYTE_W;

   // Elaboration-time parameter checks
   if (BYTE_W < 1) begin : g_bad_byte_w
      $error("BYTE_W must be at least 1");
   end
   if (NUM_BYTES < 1) begin : g_bad_num_bytes
      $error("NUM_BYTES must be at least 1");
   end
   if (SHARED_TREES != 0 && SHARED_TREES != 1) begin : g_bad_shared
      $error("SHARED_TREES must be 0 or 1");
   end

   bpu_acc_t acc;
   bpu_src_e src;

   logic [W-1:0]         mbx_q;
   logic [W-1:0]         chk_word;
   logic [DW-1:0]        chk_data;
   logic [NUM_BYTES-1:0] chk_msb;
   logic [NUM_BYTES-1:0] chk_gen;
   logic [NUM_BYTES-1:0] chk_bad;
   logic [NUM_BYTES-1:0] mbx_gen;
   logic [DW-1:0]        fifo_data;
   logic [NUM_BYTES-1:0] fifo_gen;
   logic [W-1:0]         sel_word;
   logic [NUM_BYTES-1:0] sel_gen;
   logic [W-1:0]         out_d;

   bpu_decode u_decode (
      .cs_n    (cs_n),
      .en      (en),
      .wr_rd   (wr_rd),
      .mbx_sel (mbx_sel),
      .gen_par (gen_par),
      .acc     (acc),
      .src     (src)
   );

   bpu_mailbox #(.W(W)) u_mailbox (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (peer_mbx_we),
      .wdata   (peer_mbx_data),
      .rd_take (acc.rd_mbx),
      .q       (mbx_q),
      .full    (mbx_full)
   );

   // FIFO write path: every bit stored as driven (R4)
   assign fifo_wr_en   = acc.wr_fifo;
   assign fifo_wr_data = bus_in;
   assign fifo_rd_en   = acc.rd_fifo;

   // Lane split of the checked word and of FIFO read data (R1)
   for (genvar k = 0; k < NUM_BYTES; k++) begin : g_split
      assign chk_data[k*BYTE_W +: BYTE_W]  = chk_word[k*LANE +: BYTE_W];
      assign chk_msb[k]                    = chk_word[k*LANE + BYTE_W];
      assign fifo_data[k*BYTE_W +: BYTE_W] = fifo_rd_data[k*LANE +: BYTE_W];
   end

   if (SHARED_TREES == 1) begin : g_shared
      // One tree set: bus check normally, mailbox generation when borrowed
      assign chk_word = acc.borrow ? mbx_q : bus_in;
      bpu_parity_tree #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_tree_chk (
         .data     (chk_data),
         .odd_sel  (odd_sel),
         .gen_bits (chk_gen)
      );
      assign mbx_gen = chk_gen;
   end else begin : g_split_trees
      logic [DW-1:0] mbx_data;
      for (genvar k = 0; k < NUM_BYTES; k++) begin : g_mlane
         assign mbx_data[k*BYTE_W +: BYTE_W] = mbx_q[k*LANE +: BYTE_W];
      end
      assign chk_word = bus_in;
      bpu_parity_tree #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_tree_chk (
         .data     (chk_data),
         .odd_sel  (odd_sel),
         .gen_bits (chk_gen)
      );
      bpu_parity_tree #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_tree_mbx (
         .data     (mbx_data),
         .odd_sel  (odd_sel),
         .gen_bits (mbx_gen)
      );
   end

   // FIFO data has its own generator, ahead of the output register (R8)
   bpu_parity_tree #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_tree_fifo (
      .data     (fifo_data),
      .odd_sel  (odd_sel),
      .gen_bits (fifo_gen)
   );

   // A lane is bad when its stored bit differs from the completing bit (R2)
   assign chk_bad   = chk_msb ^ chk_gen;
   assign par_err_n = acc.borrow | ~(|chk_bad);

   // Source select and substitution on the output path only (R6, R7)
   assign sel_word = (src == SRC_MBX) ? mbx_q   : fifo_rd_data;
   assign sel_gen  = (src == SRC_MBX) ? mbx_gen : fifo_gen;

   bpu_subst #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_subst (
      .d        (sel_word),
      .gen_bits (sel_gen),
      .gen_en   (gen_par),
      .q        (out_d)
   );

   bpu_out_stage #(.W(W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (acc.rd_any),
      .d     (out_d),
      .q     (dout)
   );

   // Lane-by-lane count of ones, written apart from the xor trees
   function automatic logic word_ok(input logic [W-1:0] w, input logic odd);
      logic ok;
      ok = 1'b1;
      for (int k = 0; k < NUM_BYTES; k++) begin
         if ((($countones(w[k*LANE +: LANE]) % 2) == 1) != odd) ok = 1'b0;
      end
      return ok;
   endfunction

   AST_ERR_FORCED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && en && !wr_rd && mbx_sel && gen_par) |-> par_err_n); // R3
   AST_ERR_MATCHES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !(!cs_n && en && !wr_rd && mbx_sel && gen_par) |-> (par_err_n == word_ok(bus_in, odd_sel))); // R2
   AST_GEN_WORD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && en && !wr_rd && gen_par) |=> word_ok(dout, $past(odd_sel))); // R7
   AST_FIFO_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_rd_en && fifo_wr_en)); // R12

endmodule

// File: tb/byte_parity_unit_tb.sv
`timescale 1ns/1ps
module byte_parity_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cs_n, en, wr_rd, mbx_sel, gen_par, odd_sel;
   logic [35:0] bus_in, peer_mbx_data, fifo_rd_data;
   logic        peer_mbx_we;
   logic        fifo_rd_en, fifo_wr_en, par_err_n, mbx_full;
   logic [35:0] fifo_wr_data, dout;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   byte_parity_unit dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cs_n          (cs_n),
      .en            (en),
      .wr_rd         (wr_rd),
      .mbx_sel       (mbx_sel),
      .gen_par       (gen_par),
      .odd_sel       (odd_sel),
      .bus_in        (bus_in),
      .peer_mbx_we   (peer_mbx_we),
      .peer_mbx_data (peer_mbx_data),
      .fifo_rd_data  (fifo_rd_data),
      .fifo_rd_en    (fifo_rd_en),
      .fifo_wr_en    (fifo_wr_en),
      .fifo_wr_data  (fifo_wr_data),
      .dout          (dout),
      .par_err_n     (par_err_n),
      .mbx_full      (mbx_full)
   );

   // {word, odd_sel, expected par_err_n}; lanes at 9k, parity bit at 9k+8
   localparam logic [37:0] VEC [0:7] = '{
      {36'h0_0000_0000, 1'b1, 1'b0},
      {36'h0_0000_0000, 1'b0, 1'b1},
      {36'hF_FFFF_FFFF, 1'b1, 1'b1},
      {36'hF_FFFF_FFFF, 1'b0, 1'b0},
      {36'h8_0402_0100, 1'b1, 1'b1},
      {36'h8_0402_0100, 1'b0, 1'b0},
      {36'h8_0002_0100, 1'b1, 1'b0},
      {36'h8_0002_0100, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      cs_n = 1'b1; en = 1'b0; wr_rd = 1'b0; mbx_sel = 1'b0; gen_par = 1'b0;
   endtask

   task automatic rd(input logic mbx, input logic gen, input logic odd);
      cs_n = 1'b0; en = 1'b1; wr_rd = 1'b0; mbx_sel = mbx; gen_par = gen; odd_sel = odd;
   endtask

   // Expected word after generation, from lane counts of ones
   function automatic logic [35:0] gen_ref(input logic [35:0] w, input logic odd);
      logic [35:0] r;
      r = w;
      for (int k = 0; k < 4; k++) begin
         if (($countones(w[k*9 +: 8]) % 2) == 1) r[k*9+8] = odd ? 1'b0 : 1'b1;
         else                                     r[k*9+8] = odd ? 1'b1 : 1'b0;
      end
      return r;
   endfunction

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [35:0] m1, m2, f1, f2;
      m1 = 36'h1_2345_6789;
      m2 = 36'h0_FEDC_BA98;
      f1 = 36'hA_5A5A_5A5A;
      f2 = 36'h3_C0FF_EE11;

      rst_n = 1'b0;
      idle();
      odd_sel = 1'b0;
      bus_in = '0; peer_mbx_data = '0; fifo_rd_data = '0; peer_mbx_we = 1'b0;
      tick(); tick();
      chk("R11 dout at reset", dout, 36'h0);
      chk("R11 mbx_full at reset", {35'h0, mbx_full}, 36'h0);
      rst_n = 1'b1;
      tick();

      // Vector walk: parity check under write access (R2, R4, R5)
      for (int i = 0; i < 8; i++) begin
         cs_n = 1'b0; en = 1'b1; wr_rd = 1'b1; mbx_sel = 1'b0; gen_par = 1'b1;
         bus_in  = VEC[i][37:2];
         odd_sel = VEC[i][1];
         #1;
         chk("R2 par_err_n vector", {35'h0, par_err_n}, {35'h0, VEC[i][0]});
         chk("R4 fifo_wr_en", {35'h0, fifo_wr_en}, 36'h1);
         chk("R4 fifo_wr_data", fifo_wr_data, VEC[i][37:2]);
         tick();
         chk("R5 dout holds on write", dout, 36'h0);
      end
      idle();
      #1;
      chk("R4 fifo_wr_en idle", {35'h0, fifo_wr_en}, 36'h0);
      bus_in = '0;

      // FIFO read, no generation (R12, R6)
      fifo_rd_data = f1;
      rd(1'b0, 1'b0, 1'b1);
      #1;
      chk("R12 fifo_rd_en on read", {35'h0, fifo_rd_en}, 36'h1);
      tick();
      chk("R6 fifo word unchanged", dout, f1);
      idle();
      #1;
      chk("R12 fifo_rd_en idle", {35'h0, fifo_rd_en}, 36'h0);

      // No access: dout holds (R5)
      fifo_rd_data = f2;
      tick();
      chk("R5 hold cs_n high", dout, f1);
      cs_n = 1'b0; en = 1'b0;
      tick();
      chk("R5 hold en low", dout, f1);
      idle();

      // Mailbox write from the peer (R10)
      peer_mbx_we = 1'b1; peer_mbx_data = m1;
      tick();
      peer_mbx_we = 1'b0;
      chk("R10 mbx_full set", {35'h0, mbx_full}, 36'h1);

      // Mailbox read: flag from bus without generation, forced with it (R3)
      bus_in = 36'h0;
      rd(1'b1, 1'b0, 1'b1);
      #1;
      chk("R3 flag follows bus without gen", {35'h0, par_err_n}, 36'h0);
      gen_par = 1'b1;
      #1;
      chk("R3 flag forced high", {35'h0, par_err_n}, 36'h1);
      tick();
      idle();
      chk("R7 mailbox generated odd", dout, gen_ref(m1, 1'b1));
      chk("R10 mbx_full cleared", {35'h0, mbx_full}, 36'h0);

      // Read again without generation: storage untouched (R9, R6)
      rd(1'b1, 1'b0, 1'b0);
      tick();
      idle();
      chk("R9 mailbox unchanged", dout, m1);

      // FIFO read with even generation; selects change after the edge (R8, R7)
      fifo_rd_data = f2;
      rd(1'b0, 1'b1, 1'b0);
      tick();
      idle();
      odd_sel = 1'b1; gen_par = 1'b1;
      chk("R7 fifo generated even", dout, gen_ref(f2, 1'b0));
      tick();
      chk("R8 selects after edge ignored", dout, gen_ref(f2, 1'b0));
      gen_par = 1'b0;

      // Peer write and local read on the same edge (R10)
      peer_mbx_we = 1'b1; peer_mbx_data = m2;
      rd(1'b1, 1'b0, 1'b1);
      tick();
      peer_mbx_we = 1'b0;
      chk("R10 read returns previous word", dout, m1);
      chk("R10 write wins full", {35'h0, mbx_full}, 36'h1);
      tick();
      idle();
      chk("R10 new word read", dout, m2);
      chk("R10 full cleared after read", {35'h0, mbx_full}, 36'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule